// File: doc/BRIEF.md
# Serial Slave Front End with Per-Transaction Clock Mode Detection

This block sits between the four serial pins of a slave device and a byte-wide command decoder. It works out the clock mode of each transaction by itself. When the select line goes low, it takes the resting level of the serial clock at that moment. A high clock means mode 3 and a low clock means mode 0. No configuration register sets the mode. After reset the block reports mode 3 until a new transaction latches something else.

All pins pass through synchronisers into the system clock domain, and edges are detected there. Incoming bits are taken on rising serial-clock edges, most-significant bit first, and each full byte goes to the decoder with a one-cycle strobe. The decoder can hand back a byte to send. That byte goes out on the data-out pin and moves on falling serial-clock edges. A separate enable tells the pad when the pin is actually driven. Raising select ends the transaction at once: a partial byte is dropped and the output returns to high impedance.

Top module: `spi_mode_detect_fe`

## Requirements
- R1: After reset, `mode3` reads 1, and `sel`, `so_oe` and `rx_valid` read 0.
- R2: On every high-to-low transition of `cs_n`, `mode3` takes the level `sck` had at that moment: 1 for a high clock (mode 3), 0 for a low clock (mode 0). `mode3` and `sel` reflect the transition within four system clocks.
- R3: `mode3` is a single bit and changes only at a select falling edge. It holds its value while `sck` toggles during a transaction.
- R4: Without a high-to-low transition on `cs_n`, activity on `sck` and `si` produces no `rx_valid` and leaves `sel` low. This includes `cs_n` held low from before reset release.
- R5: While selected, `si` is sampled on each rising `sck` edge, most-significant bit first. After every eighth sample `rx_byte` holds the byte, and `rx_valid` is high for exactly one system clock.
- R6: A `tx_load` pulse while selected places bit 7 of `tx_byte` on `so` at once. Each falling `sck` edge then moves to the next lower bit. In mode 3, the single falling edge that comes before the first rising edge does not advance.
- R7: `so_oe` is high only while selected with a loaded byte that still has bits to present. It drops after the eighth advance. `so` reads 0 whenever `so_oe` is low.
- R8: A rising `cs_n` drops `so_oe` and `sel`, and discards any partial input byte. The next transaction starts a new byte from its first bit.
- R9: `tx_load` while not selected has no effect: `so_oe` stays low after the following select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Active-low select pin |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the data-out pad |
| rx_byte | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| tx_byte | input | DATA_W | Byte to transmit |
| tx_load | input | 1 | Load strobe for `tx_byte` |
| sel | output | 1 | Synchronised select state |
| mode3 | output | 1 | Latched mode, 1 = mode 3, 0 = mode 0 |

## Verification
Transactions run in both modes with random payloads of one to three bytes. This checks that byte assembly does not depend on which idle clock level began the transaction. It also shows that the leading falling edge in mode 3 does not shift out an extra bit. Bit counts that are not a multiple of eight, followed by a full transaction, tell a discarded fragment apart from one carried over. Clock and data toggling with select high, or with select low since reset, tells an edge-triggered start apart from a level-triggered one. A load pulse before select confirms that only loads made while selected can enable the output.

// File: rtl/spi_ad_pkg.sv
package spi_ad_pkg;
  typedef enum logic {
    MODE_0 = 1'b0,
    MODE_3 = 1'b1
  } spi_mode_e;
endpackage

// File: rtl/spi_ad_rst_sync.sv
module spi_ad_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/spi_ad_sync.sv
module spi_ad_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st_q [STAGES];
  logic [WIDTH-1:0] st_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb st_d[s] = d;
    end else begin : g_rest
      always_comb st_d[s] = st_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[s] <= RST_VAL;
      else        st_q[s] <= st_d[s];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/spi_ad_mode.sv
module spi_ad_mode
  import spi_ad_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n_s,
  input  logic      sck_s,
  output logic      cs_fall,
  output logic      sel,
  output spi_mode_e mode
);
  logic      cs_q, cs_d;
  logic      sel_d;
  logic      mode_en;
  spi_mode_e mode_d;

  always_comb begin
    cs_fall = cs_q & ~cs_n_s;
    cs_d    = cs_n_s;
    mode_en = cs_fall;
    mode_d  = sck_s ? MODE_3 : MODE_0;
    sel_d   = sel;
    if (cs_fall)     sel_d = 1'b1;
    else if (cs_n_s) sel_d = 1'b0;
  end

  // Edge register resets low: select must be seen high before a fall counts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sel  <= 1'b0;
      mode <= MODE_3;
    end else begin
      cs_q <= cs_d;
      sel  <= sel_d;
      if (mode_en) mode <= mode_d;
    end
  end

  a_r2_latch_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (mode == ($past(sck_s) ? MODE_3 : MODE_0)));
  a_r3_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(mode));
  a_r4_select_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel) |-> $past(cs_fall));
  a_r8_release_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !sel);
endmodule

// File: rtl/spi_ad_shift.sv
module spi_ad_shift
  import spi_ad_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  spi_mode_e         mode,
  input  logic              sck_s,
  input  logic              si_s,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_load,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              so,
  output logic              so_oe
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sck_q;
  logic              sck_rise, sck_fall;
  logic              seen_rise_q, seen_rise_d;
  logic              shift_en;
  logic [DATA_W-1:0] in_sr_q, in_sr_d;
  logic [CNT_W-1:0]  in_cnt_q, in_cnt_d;
  logic [DATA_W-1:0] rx_byte_d;
  logic              rx_valid_d;
  logic [DATA_W-1:0] out_sr_q, out_sr_d;
  logic [CNT_W-1:0]  out_cnt_q, out_cnt_d;
  logic              have_q, have_d;

  always_comb begin
    sck_rise = ~sck_q & sck_s;
    sck_fall = sck_q & ~sck_s;
    shift_en = sel & sck_fall & ((mode == MODE_0) | seen_rise_q);

    seen_rise_d = seen_rise_q;
    if (!sel)          seen_rise_d = 1'b0;
    else if (sck_rise) seen_rise_d = 1'b1;

    in_sr_d    = in_sr_q;
    in_cnt_d   = in_cnt_q;
    rx_byte_d  = rx_byte;
    rx_valid_d = 1'b0;
    if (!sel) begin
      in_cnt_d = '0;
    end else if (sck_rise) begin
      in_sr_d  = {in_sr_q[DATA_W-2:0], si_s};
      in_cnt_d = (in_cnt_q == LAST) ? '0 : in_cnt_q + 1'b1;
      if (in_cnt_q == LAST) begin
        rx_byte_d  = {in_sr_q[DATA_W-2:0], si_s};
        rx_valid_d = 1'b1;
      end
    end

    out_sr_d  = out_sr_q;
    out_cnt_d = out_cnt_q;
    have_d    = have_q;
    if (!sel) begin
      have_d    = 1'b0;
      out_cnt_d = '0;
    end else if (tx_load) begin
      out_sr_d  = tx_byte;
      out_cnt_d = '0;
      have_d    = 1'b1;
    end else if (shift_en && have_q) begin
      out_sr_d  = {out_sr_q[DATA_W-2:0], 1'b0};
      out_cnt_d = out_cnt_q + 1'b1;
      if (out_cnt_q == LAST) have_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q       <= 1'b1;
      seen_rise_q <= 1'b0;
      in_sr_q     <= '0;
      in_cnt_q    <= '0;
      rx_byte     <= '0;
      rx_valid    <= 1'b0;
      out_sr_q    <= '0;
      out_cnt_q   <= '0;
      have_q      <= 1'b0;
    end else begin
      sck_q       <= sck_s;
      seen_rise_q <= seen_rise_d;
      in_sr_q     <= in_sr_d;
      in_cnt_q    <= in_cnt_d;
      rx_byte     <= rx_byte_d;
      rx_valid    <= rx_valid_d;
      out_sr_q    <= out_sr_d;
      out_cnt_q   <= out_cnt_d;
      have_q      <= have_d;
    end
  end

  assign so_oe = have_q & sel;
  assign so    = so_oe & out_sr_q[DATA_W-1];

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (in_cnt_q == '0));
  a_r6_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && sck_q && sck_s && !tx_load) |=> ($stable(out_sr_q) && $stable(have_q)));
  a_r7_oe_off_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !so_oe);
endmodule

// File: rtl/spi_mode_detect_fe.sv
module spi_mode_detect_fe
  import spi_ad_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_load,
  output logic              sel,
  output logic              mode3
);
  logic      rst_n_s;
  logic      sck_s, cs_n_s, si_s;
  logic      cs_fall;
  spi_mode_e mode;

  spi_ad_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  spi_ad_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sck (
    .clk(clk), .rst_n(rst_n_s), .d(sck), .q(sck_s));
  spi_ad_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cs (
    .clk(clk), .rst_n(rst_n_s), .d(cs_n), .q(cs_n_s));
  spi_ad_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si (
    .clk(clk), .rst_n(rst_n_s), .d(si), .q(si_s));

  spi_ad_mode u_mode (
    .clk(clk), .rst_n(rst_n_s), .cs_n_s(cs_n_s), .sck_s(sck_s),
    .cs_fall(cs_fall), .sel(sel), .mode(mode));

  spi_ad_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .sel(sel), .mode(mode),
    .sck_s(sck_s), .si_s(si_s), .tx_byte(tx_byte), .tx_load(tx_load),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .so(so), .so_oe(so_oe));

  assign mode3 = (mode == MODE_3);

  a_r7_so_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    !so_oe |-> !so);
  a_r1_reset_mode: assert property (@(posedge clk)
    !rst_n_s |=> mode3);
endmodule

// File: tb/spi_mode_detect_fe_tb_top.sv
module spi_mode_detect_fe_tb_top;
  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si, tx_load;
  logic [7:0] tx_byte;
  logic so, so_oe, rx_valid, sel, mode3;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] got [0:1023];
  int got_n = 0;

  always #5 clk = ~clk;

  spi_mode_detect_fe dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .tx_byte(tx_byte), .tx_load(tx_load), .sel(sel), .mode3(mode3));

  always @(posedge clk) begin
    if (rx_valid && got_n < 1024) begin
      got[got_n] <= rx_byte;
      got_n <= got_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input logic [31:0] d, input int k);
    return d[31-8*k -: 8];
  endfunction

  function automatic bit exp_oe_after(input bit m3, input int nbits);
    int shifts;
    shifts = m3 ? nbits - 1 : nbits;
    return shifts < 8;
  endfunction

  task automatic do_reset(input logic cs_level);
    rst_n = 1'b0; cs_n = cs_level; sck = 1'b1; si = 1'b0;
    tx_load = 1'b0; tx_byte = 8'h00;
    waitc(4);
    rst_n = 1'b1;
    waitc(6);
  endtask

  // One transaction; data bits are din[31] downwards.
  task automatic xfer(input bit m3, input int nbits, input logic [31:0] din,
                      input bit do_load, input logic [7:0] tx);
    int base;
    base = got_n;
    sck = m3; waitc(12);
    cs_n = 1'b0; waitc(4);
    chk("R2 sel", sel, 1'b1);
    chk("R2 mode", mode3, m3);
    waitc(8);
    chk("R7 oe before load", so_oe, 1'b0);
    if (do_load) begin
      tx_byte = tx; tx_load = 1'b1; waitc(1); tx_load = 1'b0; waitc(4);
      chk("R7 oe after load", so_oe, 1'b1);
    end
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; si = din[31-i]; waitc(10);
      if (do_load && i < 8) chk("R6 so bit", so, tx[7-i]);
      sck = 1'b1; waitc(10);
    end
    if (!m3) begin sck = 1'b0; waitc(10); end
    chk("R3 mode held", mode3, m3);
    if (do_load) chk("R7 oe after bits", so_oe, exp_oe_after(m3, nbits));
    waitc(2);
    chk("R5 byte count", got_n - base, nbits / 8);
    for (int k = 0; k < nbits / 8; k++)
      chk("R5 byte value", got[base+k], exp_byte(din, k));
    cs_n = 1'b1; waitc(6);
    chk("R8 oe released", so_oe, 1'b0);
    chk("R8 sel released", sel, 1'b0);
    chk("R7 so quiet", so, 1'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd4711));
    do_reset(1'b1);
    // R1 reset state
    chk("R1 mode3", mode3, 1'b1);
    chk("R1 sel", sel, 1'b0);
    chk("R1 oe", so_oe, 1'b0);
    chk("R1 rx_valid", rx_valid, 1'b0);

    // R4 toggling with select high
    base = got_n;
    for (int i = 0; i < 16; i++) begin
      sck = ~sck; si = $urandom(); waitc(6);
    end
    chk("R4 no byte cs high", got_n - base, 0);
    chk("R4 sel low", sel, 1'b0);

    // Directed mode 0 and mode 3
    xfer(1'b0, 8, 32'hA5000000, 1'b1, 8'h3C);
    xfer(1'b1, 8, 32'h5A000000, 1'b1, 8'hC3);
    chk("R2 mode3 after mode0", mode3, 1'b1);
    xfer(1'b1, 16, 32'h81FF0000, 1'b1, 8'h96);

    // R8 partial byte then full byte
    xfer(1'b0, 5, 32'hF8000000, 1'b0, 8'h00);
    xfer(1'b0, 8, 32'h01000000, 1'b0, 8'h00);
    xfer(1'b1, 11, 32'hFFE00000, 1'b1, 8'h55);
    xfer(1'b1, 8, 32'h00000000, 1'b0, 8'h00);

    // R9 load while deselected
    tx_byte = 8'hFF; tx_load = 1'b1; waitc(1); tx_load = 1'b0; waitc(3);
    sck = 1'b1; cs_n = 1'b0; waitc(8);
    chk("R9 no oe", so_oe, 1'b0);
    cs_n = 1'b1; waitc(8);

    // Random transactions
    for (int t = 0; t < 24; t++) begin
      bit m;
      int nb;
      m = $urandom_range(0, 1);
      nb = (t % 4 == 3) ? $urandom_range(1, 23) : 8 * $urandom_range(1, 3);
      xfer(m, nb, $urandom(), $urandom_range(0, 1), 8'($urandom()));
    end

    // R4 select low from before reset release; R1 default mode after reset
    do_reset(1'b0);
    chk("R1 mode3 after reset", mode3, 1'b1);
    base = got_n;
    for (int i = 0; i < 16; i++) begin
      sck = ~sck; si = $urandom(); waitc(6);
    end
    chk("R4 no byte cs low at reset", got_n - base, 0);
    chk("R4 sel stays low", sel, 1'b0);
    cs_n = 1'b1; waitc(8);
    xfer(1'b0, 8, 32'hC6000000, 1'b1, 8'h6C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule